// File: doc/BRIEF.md
# Local Alignment Score Array (Linear Gap)

This block scores a subject sequence against a stored query using the local-alignment dynamic programme with a linear gap cost. It is a chain of `NUM_PE` identical cells, and each cell stands for one query position. Each cell keeps the substitution scores that its query symbol earns against every symbol of the alphabet. Subject symbols enter at cell 0 and move one cell to the right on every clock. Each cell passes three things to its right neighbour: its newest cell score, the subject symbol and a running column maximum. A tracker after the last cell keeps the largest value seen for the current subject sequence. It reports that value once the final symbol has cleared the chain.

Before a scan, software-side logic writes the substitution entries for each cell, and one shared gap cost, through a load port. Subject symbols then arrive on a valid/ready stream. A start flag marks the first symbol of each sequence and an end flag marks the last. A new sequence may follow the previous one with no idle cycle. All scores are unsigned, `SCORE_W` bits wide, and clamped into the range 0 to 2^SCORE_W-1.

A three-state controller arbitrates between loading and streaming:
- **IDLE**: the pipeline is empty and loads are accepted. A load has priority, so `s_ready` is low while `ld_valid` is high. An accepted symbol moves the controller to STREAM.
- **STREAM**: symbols are in flight and loads are ignored. A cycle with no accepted symbol moves the controller to DRAIN.
- **DRAIN**: a countdown of `NUM_PE+1` cycles lets the last symbol and its result leave the chain. An accepted symbol moves the controller back to STREAM. When the countdown expires, the controller returns to IDLE.

Top module: `sw_scan_array`

## Requirements
- R1: After reset, `res_valid` is 0, `s_ready` is 1, every substitution entry is 0 and the gap cost is 0. A sequence streamed with no loads therefore scores 0.
- R2: In IDLE, `ld_valid` with `ld_gap`=0 writes `ld_val` as a SUB_W-bit two's complement value into row `ld_row` of cell `ld_pe`. The row is the subject symbol code. With `ld_gap`=1, `ld_val` is read as an unsigned gap cost that all cells share.
- R3: In IDLE, `s_ready` is 0 while `ld_valid` is 1. In every other case `s_ready` is 1.
- R4: A load presented while the controller is in STREAM or DRAIN changes nothing. Later results use the earlier table and gap.
- R5: For query symbol q(i) in cell i and subject symbol s(j), the cell score is H(i,j) = max(0, clamp(H(i-1,j-1)+sub(q(i),s(j))), H(i-1,j)-g, H(i,j-1)-g). Any H outside the matrix is 0. The reported result is the largest H over the whole matrix of one sequence.
- R6: A negative sum or difference clamps to 0. A subject that scores only negatively against the query reports 0.
- R7: A sum above 2^SCORE_W-1 clamps to 2^SCORE_W-1.
- R8: `res_valid` is high for one cycle per sequence. It first shows exactly NUM_PE+2 rising edges after the edge that accepts the symbol flagged `s_last`, counting that edge as the first.
- R9: A sequence that starts on the cycle after the previous sequence's last symbol is scored independently. Results come out in input order.
- R10: Idle cycles inside a sequence (`s_valid` low) leave its result unchanged.
- R11: A load with `ld_pe` >= NUM_PE, or with `ld_row` >= ALPHA and `ld_gap`=0, writes nothing. A subject symbol code >= ALPHA uses substitution score 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request |
| ld_gap | input | 1 | 1: load the gap cost, 0: load a substitution entry |
| ld_pe | input | PE_W | Target cell index |
| ld_row | input | CHAR_W | Subject symbol row within the cell's column |
| ld_val | input | SUB_W | Substitution score (signed) or gap cost (unsigned) |
| s_valid | input | 1 | Subject symbol valid |
| s_ready | output | 1 | Subject symbol accepted when high with s_valid |
| s_char | input | CHAR_W | Subject symbol code |
| s_first | input | 1 | Marks the first symbol of a sequence |
| s_last | input | 1 | Marks the last symbol of a sequence |
| res_valid | output | 1 | One-cycle result strobe |
| res_score | output | SCORE_W | Best local score of the finished sequence |

## Verification
The bench builds the array with five cells, a three-symbol alphabet in a 2-bit code, 5-bit substitution values and a 6-bit score. With a 6-bit score, five matches of +15 along a diagonal go past the ceiling of 63, so the top clamp is exercised. The 2-bit symbol code leaves row 3 out of range, and the 3-bit cell index leaves cells 5 to 7 out of range. Both kinds of ignored load can therefore be tried through the ports. Five cells also keep the latency window short, which lets back-to-back, bubbled and mid-stream-load cases run in a few hundred cycles.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_DRAIN  = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/sw_ctrl.sv
module sw_ctrl
    import sw_pkg::*;
#(
    parameter int NUM_PE = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_valid,
    input  logic        ld_valid,
    output logic        s_ready,
    output logic        take_char,
    output logic        ld_take,
    output ctrl_state_e state_o
);

    localparam int DRAIN_CYC = NUM_PE + 1;
    localparam int CNT_W     = $clog2(DRAIN_CYC + 1);

    ctrl_state_e       state_q;
    ctrl_state_e       state_d;
    logic [CNT_W-1:0]  cnt_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_char) state_d = ST_STREAM;
            ST_STREAM: if (!take_char) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (take_char)          state_d = ST_STREAM;
                else if (cnt_q == '0)   state_d = ST_IDLE;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and drain countdown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_DRAIN && state_q != ST_DRAIN)
                cnt_q <= CNT_W'(DRAIN_CYC);
            else if (state_q == ST_DRAIN && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs per state
    always_comb begin
        s_ready = 1'b1;
        ld_take = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                s_ready = !ld_valid;
                ld_take = ld_valid;
            end
            ST_STREAM, ST_DRAIN: begin
                s_ready = 1'b1;
                ld_take = 1'b0;
            end
            default: begin
                s_ready = 1'b0;
                ld_take = 1'b0;
            end
        endcase
    end

    assign take_char = s_valid && s_ready;
    assign state_o   = state_q;

endmodule

// File: rtl/sw_cell.sv
module sw_cell #(
    parameter int IDX     = 0,
    parameter int PE_W    = 3,
    parameter int ALPHA   = 24,
    parameter int CHAR_W  = 5,
    parameter int SUB_W   = 6,
    parameter int SCORE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [PE_W-1:0]            cfg_pe,
    input  logic [CHAR_W-1:0]          cfg_row,
    input  logic [SUB_W-1:0]           cfg_val,
    input  logic [SUB_W-1:0]           gap,
    input  logic [CHAR_W-1:0]          c_in,
    input  logic                       v_in,
    input  logic                       f_in,
    input  logic                       l_in,
    input  logic [SCORE_W-1:0]         h_in,
    input  logic [SCORE_W-1:0]         m_in,
    output logic [CHAR_W-1:0]          c_out,
    output logic                       v_out,
    output logic                       f_out,
    output logic                       l_out,
    output logic [SCORE_W-1:0]         h_q,
    output logic [SCORE_W-1:0]         m_q
);

    localparam int SW = ((SCORE_W > SUB_W) ? SCORE_W : SUB_W) + 2;
    localparam logic signed [SW-1:0] TOP_S = {{(SW-SCORE_W){1'b0}}, {SCORE_W{1'b1}}};

    logic signed [SUB_W-1:0]   col [ALPHA];
    logic signed [SUB_W-1:0]   sub_sel;
    logic [SCORE_W-1:0]        diag;
    logic signed [SW-1:0]      diag_sum;
    logic [SCORE_W-1:0]        diag_sat;
    logic [SCORE_W-1:0]        d1;
    logic [SCORE_W-1:0]        up_g;
    logic [SCORE_W-1:0]        left_g;
    logic [SCORE_W-1:0]        h_new;
    logic [SCORE_W-1:0]        m_new;

    function automatic logic [SCORE_W-1:0] minus_floor(
        input logic [SCORE_W-1:0] a,
        input logic [SUB_W-1:0]   g
    );
        logic [SW-1:0] ae;
        logic [SW-1:0] ge;
        ae = SW'(a);
        ge = SW'(g);
        return (ae > ge) ? SCORE_W'(ae - ge) : '0;
    endfunction

    function automatic logic [SCORE_W-1:0] umax(
        input logic [SCORE_W-1:0] a,
        input logic [SCORE_W-1:0] b
    );
        return (a > b) ? a : b;
    endfunction

    // substitution column storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ALPHA; r++) col[r] <= '0;
        end else if (cfg_we && cfg_pe == PE_W'(IDX)) begin
            for (int r = 0; r < ALPHA; r++)
                if (cfg_row == CHAR_W'(r)) col[r] <= cfg_val;
        end
    end

    // lookup by subject symbol; codes outside the alphabet score 0
    always_comb begin
        sub_sel = '0;
        for (int r = 0; r < ALPHA; r++)
            if (c_in == CHAR_W'(r)) sub_sel = col[r];
    end

    // stage 1: diagonal plus substitution, clamped both ways
    always_comb begin
        diag     = f_in ? '0 : h_in;
        diag_sum = $signed(SW'(diag)) + SW'(sub_sel);
        if (diag_sum < 0)
            diag_sat = '0;
        else if (diag_sum > TOP_S)
            diag_sat = '1;
        else
            diag_sat = diag_sum[SCORE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_out <= '0;
            v_out <= 1'b0;
            f_out <= 1'b0;
            l_out <= 1'b0;
            d1    <= '0;
        end else begin
            c_out <= c_in;
            v_out <= v_in;
            f_out <= f_in;
            l_out <= l_in;
            if (v_in) d1 <= diag_sat;
        end
    end

    // stage 2: cell score and column maximum
    always_comb begin
        up_g   = minus_floor(h_in, gap);
        left_g = minus_floor(f_out ? '0 : h_q, gap);
        h_new  = umax(d1, umax(up_g, left_g));
        m_new  = umax(m_in, h_new);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
            m_q <= '0;
        end else if (v_out) begin
            h_q <= h_new;
            m_q <= m_new;
        end
    end

endmodule

// File: rtl/sw_peak.sv
module sw_peak #(
    parameter int SCORE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               v_in,
    input  logic               f_in,
    input  logic               l_in,
    input  logic [SCORE_W-1:0] colmax,
    output logic               res_valid,
    output logic [SCORE_W-1:0] res_score
);

    logic               v_d;
    logic               f_d;
    logic               l_d;
    logic [SCORE_W-1:0] acc_q;
    logic [SCORE_W-1:0] acc_nxt;

    always_comb begin
        if (f_d)
            acc_nxt = colmax;
        else
            acc_nxt = (colmax > acc_q) ? colmax : acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_d       <= 1'b0;
            f_d       <= 1'b0;
            l_d       <= 1'b0;
            acc_q     <= '0;
            res_valid <= 1'b0;
            res_score <= '0;
        end else begin
            v_d       <= v_in;
            f_d       <= f_in;
            l_d       <= l_in;
            res_valid <= v_d && l_d;
            if (v_d) acc_q <= acc_nxt;
            if (v_d && l_d) res_score <= acc_nxt;
        end
    end

    AST_RES_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(v_in && l_in, 2)); // R8

endmodule

// File: rtl/sw_scan_array.sv
module sw_scan_array
    import sw_pkg::*;
#(
    parameter int NUM_PE  = 8,
    parameter int ALPHA   = 24,
    parameter int CHAR_W  = 5,
    parameter int SUB_W   = 6,
    parameter int SCORE_W = 16,
    localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic               ld_gap,
    input  logic [PE_W-1:0]    ld_pe,
    input  logic [CHAR_W-1:0]  ld_row,
    input  logic [SUB_W-1:0]   ld_val,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [CHAR_W-1:0]  s_char,
    input  logic               s_first,
    input  logic               s_last,
    output logic               res_valid,
    output logic [SCORE_W-1:0] res_score
);

    ctrl_state_e         state;
    logic                take_char;
    logic                ld_take;
    logic [SUB_W-1:0]    gap_q;

    logic [CHAR_W-1:0]   c_w [NUM_PE+1];
    logic [NUM_PE:0]     v_w;
    logic [NUM_PE:0]     f_w;
    logic [NUM_PE:0]     l_w;
    logic [SCORE_W-1:0]  h_w [NUM_PE+1];
    logic [SCORE_W-1:0]  m_w [NUM_PE+1];

    sw_ctrl #(.NUM_PE(NUM_PE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .ld_valid  (ld_valid),
        .s_ready   (s_ready),
        .take_char (take_char),
        .ld_take   (ld_take),
        .state_o   (state)
    );

    // shared gap cost
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= '0;
        else if (ld_take && ld_gap)
            gap_q <= ld_val;
    end

    assign c_w[0] = s_char;
    assign v_w[0] = take_char;
    assign f_w[0] = s_first;
    assign l_w[0] = s_last;
    assign h_w[0] = '0;
    assign m_w[0] = '0;

    for (genvar i = 0; i < NUM_PE; i++) begin : g_cell
        sw_cell #(
            .IDX     (i),
            .PE_W    (PE_W),
            .ALPHA   (ALPHA),
            .CHAR_W  (CHAR_W),
            .SUB_W   (SUB_W),
            .SCORE_W (SCORE_W)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (ld_take && !ld_gap),
            .cfg_pe  (ld_pe),
            .cfg_row (ld_row),
            .cfg_val (ld_val),
            .gap     (gap_q),
            .c_in    (c_w[i]),
            .v_in    (v_w[i]),
            .f_in    (f_w[i]),
            .l_in    (l_w[i]),
            .h_in    (h_w[i]),
            .m_in    (m_w[i]),
            .c_out   (c_w[i+1]),
            .v_out   (v_w[i+1]),
            .f_out   (f_w[i+1]),
            .l_out   (l_w[i+1]),
            .h_q     (h_w[i+1]),
            .m_q     (m_w[i+1])
        );

        AST_CHAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            v_w[i+1] |-> ($past(v_w[i]) && c_w[i+1] == $past(c_w[i]))); // R8
    end

    for (genvar k = 1; k < NUM_PE; k++) begin : g_chk
        AST_COLMAX_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
            $past(v_w[k+1]) |-> (m_w[k+1] >= $past(m_w[k]) && m_w[k+1] >= h_w[k+1])); // R5
    end

    sw_peak #(.SCORE_W(SCORE_W)) u_peak (
        .clk       (clk),
        .rst_n     (rst_n),
        .v_in      (v_w[NUM_PE]),
        .f_in      (f_w[NUM_PE]),
        .l_in      (l_w[NUM_PE]),
        .colmax    (m_w[NUM_PE]),
        .res_valid (res_valid),
        .res_score (res_score)
    );

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ld_take |-> (v_w[NUM_PE:1] == '0)); // R4

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (v_w[NUM_PE:1] == '0 && !res_valid)); // R4

endmodule

// File: tb/sim_sw_scan_array.sv
`timescale 1ns/1ps
module sim_sw_scan_array;

    localparam int NPE  = 5;
    localparam int MAXV = 63;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_valid = 1'b0;
    logic       ld_gap = 1'b0;
    logic [2:0] ld_pe = '0;
    logic [1:0] ld_row = '0;
    logic [4:0] ld_val = '0;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [1:0] s_char = '0;
    logic       s_first = 1'b0;
    logic       s_last = 1'b0;
    logic       res_valid;
    logic [5:0] res_score;

    sw_scan_array #(
        .NUM_PE(NPE), .ALPHA(3), .CHAR_W(2), .SUB_W(5), .SCORE_W(6)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_gap(ld_gap), .ld_pe(ld_pe),
        .ld_row(ld_row), .ld_val(ld_val),
        .s_valid(s_valid), .s_ready(s_ready), .s_char(s_char),
        .s_first(s_first), .s_last(s_last),
        .res_valid(res_valid), .res_score(res_score)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_acc = 0;
    int res_cyc = 0;
    bit done = 0;
    int q [NPE] = '{0, 1, 2, 0, 1};
    int tbl [4][4];
    int g = 0;
    int subj [64];
    int rq [$];
    int exp_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            rq.push_back(int'(res_score));
            res_cyc = cyc;
        end
    end

    task automatic chk(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int model(input int n);
        int hm [NPE+1][65];
        int best = 0;
        for (int i = 0; i <= NPE; i++)
            for (int j = 0; j <= n; j++) hm[i][j] = 0;
        for (int i = 1; i <= NPE; i++) begin
            for (int j = 1; j <= n; j++) begin
                int d, up, lf, h;
                d = hm[i-1][j-1] + tbl[q[i-1]][subj[j-1]];
                if (d < 0) d = 0;
                if (d > MAXV) d = MAXV;
                up = hm[i-1][j] - g; if (up < 0) up = 0;
                lf = hm[i][j-1] - g; if (lf < 0) lf = 0;
                h = d;
                if (up > h) h = up;
                if (lf > h) h = lf;
                hm[i][j] = h;
                if (h > best) best = h;
            end
        end
        return best;
    endfunction

    function automatic void set_tbl(input int mt, input int mm);
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                tbl[a][b] = (a < 3 && b < 3) ? ((a == b) ? mt : mm) : 0;
    endfunction

    task automatic ld(input bit kind, input int pe, input int row, input int val, input bit see_ready);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_gap   = kind;
        ld_pe    = pe[2:0];
        ld_row   = row[1:0];
        ld_val   = val[4:0];
        #1;
        if (see_ready) chk("R3 s_ready low during idle load", int'(s_ready), 0);
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic load_all();
        for (int pe = 0; pe < NPE; pe++)
            for (int r = 0; r < 3; r++)
                ld(1'b0, pe, r, tbl[q[pe]][r], 1'b0);
        ld(1'b1, 0, 0, g, 1'b0);
    endtask

    task automatic send_seq(input int n, input int bub);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_char  = subj[k][1:0];
            s_first = (k == 0);
            s_last  = (k == n - 1);
            #1;
            while (!s_ready) begin
                @(negedge clk);
                #1;
            end
            last_acc = cyc;
            @(posedge clk);
            if (bub > 0 && k < n - 1) begin
                @(negedge clk);
                s_valid = 1'b0;
                repeat (bub - 1) @(negedge clk);
            end
        end
    endtask

    task automatic idle_bus();
        @(negedge clk);
        s_valid = 1'b0;
        s_first = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic drain_check(input string req);
        int t = 0;
        while (rq.size() < exp_q.size() && t < 200) begin
            @(posedge clk);
            t++;
        end
        repeat (2) @(posedge clk);
        chk({req, " result count"}, rq.size(), exp_q.size());
        while (exp_q.size() > 0) begin
            int e = exp_q.pop_front();
            if (rq.size() > 0) chk(req, rq.pop_front(), e);
            else chk(req, -1, e);
        end
        rq.delete();
        repeat (NPE + 6) @(posedge clk);
    endtask

    function automatic void put(input int n, input int s0, input int s1, input int s2,
                                input int s3, input int s4, input int s5);
        int v [6] = '{s0, s1, s2, s3, s4, s5};
        for (int k = 0; k < n; k++) subj[k] = v[k];
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1 res_valid after reset", int'(res_valid), 0);
        chk("R1 s_ready after reset", int'(s_ready), 1);
        set_tbl(0, 0);
        g = 0;
        put(4, 0, 1, 2, 0, 0, 0);
        send_seq(4, 0);
        idle_bus();
        exp_q.push_back(0);
        drain_check("R1 zero table score");
    endtask

    task automatic t_load_match();
        set_tbl(5, -4);
        g = 3;
        ld(1'b0, 0, 0, tbl[q[0]][0], 1'b1);
        load_all();
        put(5, 0, 1, 2, 0, 1, 0);
        send_seq(5, 0);
        idle_bus();
        exp_q.push_back(25);
        drain_check("R2 R5 full match");
        put(6, 2, 0, 1, 1, 0, 1);
        send_seq(6, 0);
        idle_bus();
        exp_q.push_back(model(6));
        drain_check("R5 gapped subject");
    endtask

    task automatic t_latency();
        put(3, 1, 2, 0, 0, 0, 0);
        exp_q.push_back(model(3));
        send_seq(3, 0);
        idle_bus();
        drain_check("R8 single result");
        chk("R8 latency edges", res_cyc - last_acc, NPE + 2);
    endtask

    task automatic t_back_to_back();
        put(4, 0, 1, 2, 2, 0, 0);
        exp_q.push_back(model(4));
        send_seq(4, 0);
        put(1, 1, 0, 0, 0, 0, 0);
        exp_q.push_back(model(1));
        send_seq(1, 0);
        put(6, 0, 1, 0, 1, 2, 0);
        exp_q.push_back(model(6));
        send_seq(6, 0);
        idle_bus();
        put(5, 2, 2, 0, 1, 2, 0);
        exp_q.push_back(model(5));
        send_seq(5, 0);
        idle_bus();
        drain_check("R9 consecutive sequences");
    endtask

    task automatic t_bubbles();
        put(6, 0, 1, 0, 1, 2, 0);
        exp_q.push_back(model(6));
        send_seq(6, 2);
        idle_bus();
        drain_check("R10 bubbled sequence");
    endtask

    task automatic t_busy_load();
        put(6, 0, 2, 0, 1, 2, 1);
        exp_q.push_back(model(6));
        fork
            send_seq(6, 0);
            begin
                repeat (3) @(negedge clk);
                ld_valid = 1'b1;
                ld_gap   = 1'b1;
                ld_val   = 5'd0;
                #1;
                chk("R3 s_ready high while streaming", int'(s_ready), 1);
                @(negedge clk);
                ld_gap   = 1'b0;
                ld_pe    = 3'd1;
                ld_row   = 2'd1;
                ld_val   = 5'd15;
                @(negedge clk);
                ld_valid = 1'b0;
            end
        join
        idle_bus();
        drain_check("R4 load during stream ignored");
        exp_q.push_back(model(6));
        send_seq(6, 0);
        idle_bus();
        drain_check("R4 table and gap kept");
    endtask

    task automatic t_out_of_range();
        ld(1'b0, 6, 0, 15, 1'b0);
        ld(1'b0, 0, 3, 15, 1'b0);
        put(5, 0, 3, 3, 1, 2, 0);
        exp_q.push_back(model(5));
        send_seq(5, 0);
        idle_bus();
        drain_check("R11 ignored loads and unknown symbol");
    endtask

    task automatic t_floor();
        set_tbl(-7, -7);
        g = 3;
        load_all();
        put(5, 0, 1, 2, 0, 1, 0);
        exp_q.push_back(0);
        send_seq(5, 0);
        idle_bus();
        drain_check("R6 all negative clamps to zero");
    endtask

    task automatic t_ceiling();
        set_tbl(15, 15);
        g = 1;
        load_all();
        put(6, 0, 0, 0, 0, 0, 0);
        exp_q.push_back(MAXV);
        send_seq(6, 0);
        idle_bus();
        drain_check("R7 saturates at top");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_match();
        t_latency();
        t_back_to_back();
        t_bubbles();
        t_busy_load();
        t_out_of_range();
        t_floor();
        t_ceiling();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule